// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small sum-of-products programmable logic device. It takes the product terms produced by the AND array for its pin, ORs them, and sends the sum either straight to the pin or through a D flip-flop. A polarity stage sits on the way to the pin. The cell also returns a signal to the AND array, taken either from the pin or from the flip-flop. Two device-wide mode bits choose the cell's behaviour together with two per-cell bits: one for polarity and one for registered or combinatorial use. That choice covers combinatorial output, registered output, or use of the pin as a dedicated input, and it also selects where the feedback comes from.

An integrator builds one instance per I/O pin and drives the mode and cell bits from the device's configuration store. A parameter marks cells that have no route back into the array. On such a cell the feedback output is always 0 and the dedicated-input option is not available. The flip-flop has a synchronous preload so that a known state can be forced.

Top module: `plc_macrocell`

## Requirements
- R1: Global mode `mode_i` = 2'b00 is reserved: `oe_o`, `pin_o` and `fb_o` are all 0.
- R2: Simple mode (`mode_i` = 2'b10) used as an output: the sum is the OR of all `N_PT` terms, it reaches `pin_o` combinatorially, `oe_o` is 1, and `fb_o` follows `pin_i`.
- R3: `pol_i` = 1 drives the selected value to `pin_o` unchanged (active-high). `pol_i` = 0 drives its inverse (active-low). This holds on every output path.
- R4: Simple mode with `rc_i` = 1 on a cell with feedback makes the pin a dedicated input: `oe_o` = 0, `pin_o` = 0, and `fb_o` = `pin_i`.
- R5: Complex mode (`mode_i` = 2'b11): term `pt_i[N_PT-1]` is the output enable, the OR covers only `pt_i[N_PT-2:0]`, and `fb_o` follows `pin_i`.
- R6: Registered mode (`mode_i` = 2'b01) with `rc_i` = 1: the flip-flop loads the OR of all terms on the rising clock edge. `pin_o` is the flip-flop value under the polarity of R3, `fb_o` is the flip-flop value, and `oe_o` = NOT `oe_ni`.
- R7: Registered mode with `rc_i` = 0: the cell is combinatorial as in R5, with the top term as enable, the lower terms ORed, and feedback from `pin_i`.
- R8: The flip-flop loads only in registered mode with `rc_i` = 1. In any other mode it holds its value.
- R9: `preload_en_i` = 1 loads `preload_d_i` into the flip-flop at the clock edge, taking priority over the sum. The flip-flop clears to 0 on `rst_ni` low.
- R10: `fb_en_i` = 0 forces `fb_o` to 0 in every mode.
- R11: With parameter `HAS_FB` = 0, `fb_o` is always 0 and `rc_i` has no effect in simple mode: the cell stays an enabled output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flip-flop |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pt_i | input | N_PT | Product terms from the AND array |
| mode_i | input | 2 | Device-wide mode bits (MS1:MS0) |
| pol_i | input | 1 | Polarity: 1 active-high, 0 active-low |
| rc_i | input | 1 | Registered or combinatorial select |
| fb_en_i | input | 1 | Per-cell feedback enable |
| pin_i | input | 1 | Value present on the pin |
| oe_ni | input | 1 | Dedicated active-low enable for registered outputs |
| preload_en_i | input | 1 | Synchronous preload strobe |
| preload_d_i | input | 1 | Preload value |
| pin_o | output | 1 | Value driven to the pin |
| oe_o | output | 1 | Pin output buffer enable |
| fb_o | output | 1 | Feedback into the logic array |

## Verification
The only state in the cell is the flip-flop. A wrong value there shows up on `fb_o` and `pin_o` in the same cycle the registered path is selected, and it may sit unseen while another mode is active. The bench loads a known state, changes modes, and checks that the state comes back unchanged. Wrong mode decoding is purely combinatorial, so it shows up on `oe_o`, `pin_o` or `fb_o` within one cycle of the inputs settling. Each mode is therefore checked right after its inputs are applied, with term patterns chosen so that the enable term and the OR terms differ.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    PLC_RSVD   = 2'b00,
    PLC_REG    = 2'b01,
    PLC_SIMPLE = 2'b10,
    PLC_CPLX   = 2'b11
  } plc_mode_e;
endpackage

// File: rtl/plc_or_plane.sv
module plc_or_plane #(
  parameter int N_PT = 8
) (
  input  logic [N_PT-1:0] pt_i,
  output logic            sum_all_o,
  output logic            sum_low_o,
  output logic            oe_term_o
);
  localparam int LowW = N_PT - 1;
  logic [LowW-1:0] low_terms;

  assign low_terms = pt_i[LowW-1:0];
  assign sum_low_o = |low_terms;
  assign oe_term_o = pt_i[N_PT-1];
  assign sum_all_o = sum_low_o | oe_term_o;
endmodule

// File: rtl/plc_dff.sv
module plc_dff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_en_i,
  input  logic d_i,
  input  logic pre_en_i,
  input  logic pre_d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (pre_en_i) q_o <= pre_d_i;
    else if (cap_en_i) q_o <= d_i;
  end
endmodule

// File: rtl/plc_route.sv
module plc_route #(
  parameter bit HAS_FB = 1'b1
) (
  input  logic [1:0] mode_i,
  input  logic       pol_i,
  input  logic       rc_i,
  input  logic       fb_en_i,
  input  logic       pin_i,
  input  logic       oe_ni,
  input  logic       sum_all_i,
  input  logic       sum_low_i,
  input  logic       oe_term_i,
  input  logic       q_i,
  output logic       pin_o,
  output logic       oe_o,
  output logic       fb_o,
  output logic       cap_en_o
);
  import plc_pkg::*;

  plc_mode_e mode;
  logic      fb_raw;

  assign mode = plc_mode_e'(mode_i);

  always_comb begin
    pin_o    = 1'b0;
    oe_o     = 1'b0;
    fb_raw   = 1'b0;
    cap_en_o = 1'b0;
    unique case (mode)
      PLC_SIMPLE: begin
        if (rc_i && HAS_FB) begin
          fb_raw = pin_i;            // dedicated input
        end else begin
          pin_o  = pol_i ? sum_all_i : ~sum_all_i;
          oe_o   = 1'b1;
          fb_raw = pin_i;
        end
      end
      PLC_CPLX: begin
        pin_o  = pol_i ? sum_low_i : ~sum_low_i;
        oe_o   = oe_term_i;
        fb_raw = pin_i;
      end
      PLC_REG: begin
        if (rc_i) begin
          pin_o    = pol_i ? q_i : ~q_i;
          oe_o     = ~oe_ni;
          fb_raw   = q_i;
          cap_en_o = 1'b1;
        end else begin
          pin_o  = pol_i ? sum_low_i : ~sum_low_i;
          oe_o   = oe_term_i;
          fb_raw = pin_i;
        end
      end
      default: ;
    endcase
  end

  assign fb_o = HAS_FB ? (fb_raw & fb_en_i) : 1'b0;
endmodule

// File: rtl/plc_macrocell.sv
module plc_macrocell #(
  parameter int N_PT   = 8,
  parameter bit HAS_FB = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PT-1:0] pt_i,
  input  logic [1:0]      mode_i,
  input  logic            pol_i,
  input  logic            rc_i,
  input  logic            fb_en_i,
  input  logic            pin_i,
  input  logic            oe_ni,
  input  logic            preload_en_i,
  input  logic            preload_d_i,
  output logic            pin_o,
  output logic            oe_o,
  output logic            fb_o
);
  logic sum_all, sum_low, oe_term, dff_q, cap_en;

  plc_or_plane #(.N_PT(N_PT)) i_or (
    .pt_i      (pt_i),
    .sum_all_o (sum_all),
    .sum_low_o (sum_low),
    .oe_term_o (oe_term)
  );

  plc_dff i_dff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (cap_en),
    .d_i      (sum_all),
    .pre_en_i (preload_en_i),
    .pre_d_i  (preload_d_i),
    .q_o      (dff_q)
  );

  plc_route #(.HAS_FB(HAS_FB)) i_route (
    .mode_i    (mode_i),
    .pol_i     (pol_i),
    .rc_i      (rc_i),
    .fb_en_i   (fb_en_i),
    .pin_i     (pin_i),
    .oe_ni     (oe_ni),
    .sum_all_i (sum_all),
    .sum_low_i (sum_low),
    .oe_term_i (oe_term),
    .q_i       (dff_q),
    .pin_o     (pin_o),
    .oe_o      (oe_o),
    .fb_o      (fb_o),
    .cap_en_o  (cap_en)
  );
endmodule

// File: rtl/plc_macrocell_chk.sv
module plc_macrocell_chk #(
  parameter int N_PT   = 8,
  parameter bit HAS_FB = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_PT-1:0] pt_i,
  input logic [1:0]      mode_i,
  input logic            rc_i,
  input logic            fb_en_i,
  input logic            oe_ni,
  input logic            preload_en_i,
  input logic            preload_d_i,
  input logic            oe_o,
  input logic            fb_o,
  input logic            q_i
);
  p_rsvd_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> (!oe_o && !fb_o));

  p_simple_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !(rc_i && HAS_FB)) |-> oe_o);

  p_ded_in_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && rc_i && HAS_FB) |-> !oe_o);

  p_cplx_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (oe_o == pt_i[N_PT-1]));

  p_reg_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && rc_i && !preload_en_i) |=> (q_i == $past(|pt_i)));

  p_reg_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && rc_i) |-> (oe_o == !oe_ni));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(mode_i == 2'b01 && rc_i) && !preload_en_i) |=> (q_i == $past(q_i)));

  p_preload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_en_i |=> (q_i == $past(preload_d_i)));

  p_fb_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_en_i |-> !fb_o);

  p_no_fb_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!HAS_FB && fb_en_i) |-> !fb_o);
endmodule

bind plc_macrocell plc_macrocell_chk #(.N_PT(N_PT), .HAS_FB(HAS_FB)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pt_i         (pt_i),
  .mode_i       (mode_i),
  .rc_i         (rc_i),
  .fb_en_i      (fb_en_i),
  .oe_ni        (oe_ni),
  .preload_en_i (preload_en_i),
  .preload_d_i  (preload_d_i),
  .oe_o         (oe_o),
  .fb_o         (fb_o),
  .q_i          (dff_q)
);

// File: tb/test_plc_macrocell.sv
`timescale 1ns/1ps
module test_plc_macrocell;
  localparam int N_PT = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_PT-1:0] pt = '0;
  logic [1:0] mode = 2'b00;
  logic pol = 1'b1, rc = 1'b0, fb_en = 1'b1, pin_in = 1'b0, oe_n = 1'b0;
  logic pre_en = 1'b0, pre_d = 1'b0;
  logic pin_o, oe_o, fb_o, pin_o2, oe_o2, fb_o2;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  plc_macrocell #(.N_PT(N_PT), .HAS_FB(1'b1)) i_plc_macrocell (
    .clk_i(clk), .rst_ni(rst_ni), .pt_i(pt), .mode_i(mode), .pol_i(pol),
    .rc_i(rc), .fb_en_i(fb_en), .pin_i(pin_in), .oe_ni(oe_n),
    .preload_en_i(pre_en), .preload_d_i(pre_d),
    .pin_o(pin_o), .oe_o(oe_o), .fb_o(fb_o));

  plc_macrocell #(.N_PT(N_PT), .HAS_FB(1'b0)) i_plc_macrocell_nofb (
    .clk_i(clk), .rst_ni(rst_ni), .pt_i(pt), .mode_i(mode), .pol_i(pol),
    .rc_i(rc), .fb_en_i(fb_en), .pin_i(pin_in), .oe_ni(oe_n),
    .preload_en_i(pre_en), .preload_d_i(pre_d),
    .pin_o(pin_o2), .oe_o(oe_o2), .fb_o(fb_o2));

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // outputs as {pin, oe, fb}
  task automatic chk3(input string req, input logic [2:0] exp);
    chk({req, " pin"}, pin_o, exp[2]);
    chk({req, " oe"},  oe_o,  exp[1]);
    chk({req, " fb"},  fb_o,  exp[0]);
  endtask

  task automatic set_comb(input logic [1:0] m, input logic r, input logic p,
                          input logic [N_PT-1:0] t, input logic pi);
    @(negedge clk);
    mode = m; rc = r; pol = p; pt = t; pin_in = pi;
    #1;
  endtask

  task automatic t_reset;
    mode = 2'b01; rc = 1'b1; pt = '1; pol = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk3("R9 reset", 3'b010);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_rsvd_r1;
    set_comb(2'b00, 1'b0, 1'b1, 8'hFF, 1'b1);
    chk3("R1 rsvd", 3'b000);
    set_comb(2'b00, 1'b1, 1'b0, 8'h00, 1'b1);
    chk3("R1 rsvd inv", 3'b000);
  endtask

  task automatic t_simple_r2_r3;
    set_comb(2'b10, 1'b0, 1'b1, 8'h00, 1'b0);
    chk3("R2 simple zero", 3'b010);
    set_comb(2'b10, 1'b0, 1'b1, 8'h80, 1'b1);
    chk3("R2 simple top term", 3'b111);
    set_comb(2'b10, 1'b0, 1'b0, 8'h01, 1'b0);
    chk3("R3 active-low one", 3'b010);
    set_comb(2'b10, 1'b0, 1'b0, 8'h00, 1'b1);
    chk3("R3 active-low zero", 3'b111);
  endtask

  task automatic t_dedicated_r4;
    set_comb(2'b10, 1'b1, 1'b1, 8'hFF, 1'b1);
    chk3("R4 ded input hi", 3'b001);
    set_comb(2'b10, 1'b1, 1'b0, 8'h00, 1'b0);
    chk3("R4 ded input lo", 3'b000);
  endtask

  task automatic t_complex_r5;
    set_comb(2'b11, 1'b0, 1'b1, 8'h81, 1'b1);
    chk3("R5 cplx en+sum", 3'b111);
    set_comb(2'b11, 1'b0, 1'b1, 8'h80, 1'b0);
    chk3("R5 cplx top not ORed", 3'b010);
    set_comb(2'b11, 1'b0, 1'b0, 8'h01, 1'b1);
    chk3("R5 cplx disabled", 3'b001);
  endtask

  task automatic t_reg_r6;
    set_comb(2'b01, 1'b1, 1'b1, 8'h04, 1'b0);
    oe_n = 1'b0;
    @(posedge clk); #1;
    chk3("R6 reg load 1", 3'b111);
    @(negedge clk); pol = 1'b0; #1;
    chk3("R6 reg active-low", 3'b011);
    @(negedge clk); pt = 8'h00; pol = 1'b1; pin_in = 1'b1;
    @(posedge clk); #1;
    chk3("R6 reg load 0", 3'b010);
    @(negedge clk); oe_n = 1'b1; #1;
    chk("R6 reg oe_n high", oe_o, 1'b0);
    oe_n = 1'b0;
  endtask

  task automatic t_regcomb_r7;
    set_comb(2'b01, 1'b0, 1'b1, 8'h82, 1'b1);
    chk3("R7 reg comb on", 3'b111);
    set_comb(2'b01, 1'b0, 1'b1, 8'h02, 1'b0);
    chk3("R7 reg comb off", 3'b100);
  endtask

  task automatic t_hold_r8;
    set_comb(2'b01, 1'b1, 1'b1, 8'h10, 1'b0);
    @(posedge clk); #1;
    chk("R8 loaded", fb_o, 1'b1);
    set_comb(2'b10, 1'b0, 1'b1, 8'h00, 1'b0);
    repeat (2) @(posedge clk);
    set_comb(2'b11, 1'b0, 1'b1, 8'h00, 1'b0);
    @(posedge clk);
    set_comb(2'b01, 1'b1, 1'b1, 8'h00, 1'b0);
    chk("R8 held across modes", fb_o, 1'b1);
    @(posedge clk); #1;
    chk("R8 reloads after return", fb_o, 1'b0);
  endtask

  task automatic t_preload_r9;
    set_comb(2'b01, 1'b1, 1'b1, 8'h00, 1'b0);
    pre_en = 1'b1; pre_d = 1'b1;
    @(posedge clk); #1;
    chk("R9 preload 1 over sum 0", fb_o, 1'b1);
    @(negedge clk); pt = 8'hFF; pre_d = 1'b0;
    @(posedge clk); #1;
    chk("R9 preload 0 over sum 1", fb_o, 1'b0);
    @(negedge clk); pre_en = 1'b0;
    @(posedge clk); #1;
    chk("R9 capture resumes", fb_o, 1'b1);
    @(negedge clk); rst_ni = 1'b0; #1;
    chk("R9 async clear", fb_o, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_fben_r10;
    set_comb(2'b01, 1'b1, 1'b1, 8'hFF, 1'b1);
    @(posedge clk); #1;
    chk("R10 fb on", fb_o, 1'b1);
    @(negedge clk); fb_en = 1'b0; #1;
    chk("R10 reg fb off", fb_o, 1'b0);
    set_comb(2'b10, 1'b1, 1'b1, 8'h00, 1'b1);
    chk("R10 ded fb off", fb_o, 1'b0);
    @(negedge clk); fb_en = 1'b1;
  endtask

  task automatic t_nofb_r11;
    set_comb(2'b10, 1'b1, 1'b1, 8'h20, 1'b1);
    chk("R11 nofb oe", oe_o2, 1'b1);
    chk("R11 nofb pin", pin_o2, 1'b1);
    chk("R11 nofb fb simple", fb_o2, 1'b0);
    set_comb(2'b01, 1'b1, 1'b1, 8'hFF, 1'b1);
    @(posedge clk); #1;
    chk("R11 nofb reg pin", pin_o2, 1'b1);
    chk("R11 nofb fb reg", fb_o2, 1'b0);
  endtask

  initial begin
    t_reset();
    t_rsvd_r1();
    t_simple_r2_r3();
    t_dedicated_r4();
    t_complex_r5();
    t_reg_r6();
    t_regcomb_r7();
    t_hold_r8();
    t_preload_r9();
    t_fben_r10();
    t_nofb_r11();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule